// File: doc/BRIEF.md
# Multi-plane video memory bus window

This block gives a processor bus one word-wide window onto up to three bitmap planes. Every plane answers to the same range of window addresses. One control register per plane holds a memory-reference enable bit, and that bit decides whether the plane takes part in processor accesses. A processor write is stored into every enabled plane at the same time, with the byte lanes chosen by the strobes. A processor read returns the word from the enabled plane with the lowest number. When no plane is enabled, an access touches no memory: a read returns zero and a write is dropped, and both still complete normally.

A second port serves the display side. It fetches the word at one address from all planes at once and also returns one pixel bit per plane. The bitmap is laid out so that bit 0 of word 0 is the top-left pixel, and pixel x of a line sits at bit x mod 16 of word x/16. The last sixteenth of each plane is never scanned out, so display fetches from that area return zero. The processor can still read and write it.

Each plane RAM has a single port, and a display fetch takes precedence over the processor on that port. A processor access that meets a display fetch in the same cycle is held off with a wait signal. The block also holds the X and Y position registers for an external transfer engine. While that engine reports that it is busy, writes to the plane control registers are dropped and writes to X and Y are still accepted. The default window is 1K words per plane. Setting ADDR_W to 14 gives the full 32 KB window, of which 30 KB is displayed.

Top module: `vw_bus_window`

## Requirements
- R1: After reset, bus_ack, bus_wait and disp_valid are 0, and all plane control registers, xfer_x and xfer_y are 0.
- R2: All planes decode the same window addresses. A word written at address A appears at address A in each plane it reaches, and the whole depth, including the hidden area, can be read and written from the bus.
- R3: Plane p takes part in bus accesses only while bit 5 of its control register is 1. The other bits of that register have no effect, and plane_mref[p] shows bit 5.
- R4: When no plane is enabled, a bus write changes no plane and a bus read returns 0x0000. Both are still acknowledged.
- R5: An accepted bus write is stored into every enabled plane in the same cycle.
- R6: A bus read returns the word from the lowest-numbered enabled plane. Plane 0 has the highest priority and plane 2 the lowest.
- R7: A bus write updates bits 7:0 only if bus_be[0] is 1 and bits 15:8 only if bus_be[1] is 1. A write with bus_be = 00 changes nothing.
- R8: A bus access is accepted on a clock edge where bus_req is 1, bus_ack is 0 and bus_wait is 0. bus_ack is then 1 for exactly the next cycle, and for a read bus_rdata carries the data during that cycle.
- R9: When disp_req is 1 at an edge, disp_valid is 1 in the next cycle. In that cycle disp_rdata[16p+15:16p] holds the word of plane p at disp_addr, and disp_pix[p] holds bit disp_bit of that word, so bit 0 of word 0 is the top-left pixel.
- R10: A display fetch at a word address at or above 15/16 of the plane depth (960 by default) returns zero for every plane.
- R11: bus_wait is 1 when bus_req is 1, bus_ack is 0, disp_req is 1 and at least one plane is enabled. The bus access is not accepted in that cycle.
- R12: reg_sel values 0 to 2 select the plane control registers, 3 selects X and 4 selects Y, and a write takes effect at the next edge. While xfer_done is 0, writes to plane control registers are ignored. Writes to X and Y are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Window word address |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte-lane strobes for writes |
| bus_ack | output | 1 | Access completed, high for one cycle |
| bus_wait | output | 1 | Access held off by a display fetch |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | clog2(NUM_PLANES+2) | Register select |
| reg_wdata | input | DATA_W | Register write data |
| xfer_done | input | 1 | Transfer engine idle |
| plane_ctl | output | NUM_PLANES*DATA_W | Plane control registers, plane p at bits 16p+15:16p |
| plane_mref | output | NUM_PLANES | Memory-reference enable of each plane |
| xfer_x | output | DATA_W | X position register |
| xfer_y | output | DATA_W | Y position register |
| disp_req | input | 1 | Display fetch request |
| disp_addr | input | ADDR_W | Display word address |
| disp_bit | input | clog2(DATA_W) | Pixel bit within the fetched word |
| disp_valid | output | 1 | Display data valid |
| disp_rdata | output | NUM_PLANES*DATA_W | Fetched word of every plane |
| disp_pix | output | NUM_PLANES | Selected pixel bit of every plane |

## Verification
Three kinds of result come due at different times. bus_wait is combinational and is due in the same cycle as the inputs that raise it. bus_ack and bus_rdata are due one edge after acceptance. disp_valid, disp_rdata and disp_pix are due one edge after the fetch request, and register contents one edge after the register write. The bench drives inputs just after a rising edge. A behavioural reference model advances at each rising edge by the same one-edge delays, and every output is compared against it at the following falling edge, so the model's value and the design's value always refer to the same cycle. The directed checks read outputs one time step after the edge that produces them.

// File: rtl/vw_pkg.sv
package vw_pkg;
    // Bit position of the memory-reference enable in each plane control register
    localparam int MREF_BIT = 5;
    // Display area is all but the last 1/HIDDEN_DIV of a plane
    localparam int HIDDEN_DIV = 16;
endpackage

// File: rtl/vw_plane_ram.sv
module vw_plane_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                en,
    input  logic                we,
    input  logic [DATA_W/8-1:0] be,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BE_W  = DATA_W / 8;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (be[b]) mem_q[addr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end else begin
                rdata_q <= mem_q[addr];
            end
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/vw_ctl_regs.sv
module vw_ctl_regs #(
    parameter int NUM_PLANES = 3,
    parameter int DATA_W     = 16,
    parameter int SEL_W      = $clog2(NUM_PLANES + 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [SEL_W-1:0]             reg_sel,
    input  logic [DATA_W-1:0]            reg_wdata,
    input  logic                         xfer_done,
    output logic [NUM_PLANES*DATA_W-1:0] plane_ctl,
    output logic [NUM_PLANES-1:0]        plane_mref,
    output logic [DATA_W-1:0]            xfer_x,
    output logic [DATA_W-1:0]            xfer_y
);
    import vw_pkg::*;

    typedef struct packed {
        logic [NUM_PLANES-1:0][DATA_W-1:0] ctl;
        logic [DATA_W-1:0]                 x;
        logic [DATA_W-1:0]                 y;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            for (int p = 0; p < NUM_PLANES; p++) begin
                if (reg_sel == SEL_W'(p) && xfer_done) regs_d.ctl[p] = reg_wdata;
            end
            if (reg_sel == SEL_W'(NUM_PLANES))     regs_d.x = reg_wdata;
            if (reg_sel == SEL_W'(NUM_PLANES + 1)) regs_d.y = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    generate
        for (genvar p = 0; p < NUM_PLANES; p++) begin : g_out
            assign plane_ctl[p*DATA_W +: DATA_W] = regs_q.ctl[p];
            assign plane_mref[p]                 = regs_q.ctl[p][MREF_BIT];
        end
    endgenerate
    assign xfer_x = regs_q.x;
    assign xfer_y = regs_q.y;

    // R12: plane control registers hold while the transfer engine is busy
    a_r12_ctl_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |=> $stable(plane_ctl));
    // R12: X register always accepts a write
    a_r12_x_always: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_W'(NUM_PLANES)) |=> xfer_x == $past(reg_wdata));
endmodule

// File: rtl/vw_rd_pick.sv
module vw_rd_pick #(
    parameter int NUM_PLANES = 3,
    parameter int DATA_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         capture,
    input  logic                         is_read,
    input  logic [NUM_PLANES-1:0]        plane_en,
    input  logic [NUM_PLANES*DATA_W-1:0] ram_rdata,
    input  logic                         ack,
    output logic [DATA_W-1:0]            rdata
);
    typedef struct packed {
        logic [NUM_PLANES-1:0] sel;
        logic                  none;
        logic                  rd;
    } pick_t;

    pick_t pick_d, pick_q;
    logic [NUM_PLANES-1:0] first_en;
    logic [DATA_W-1:0]     word;

    always_comb begin
        logic found;
        found    = 1'b0;
        first_en = '0;
        for (int p = 0; p < NUM_PLANES; p++) begin
            if (plane_en[p] && !found) begin
                first_en[p] = 1'b1;
                found       = 1'b1;
            end
        end
        pick_d = pick_q;
        if (capture) begin
            pick_d.sel  = first_en;
            pick_d.none = ~|plane_en;
            pick_d.rd   = is_read;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pick_q <= '0;
        else        pick_q <= pick_d;
    end

    always_comb begin
        word = '0;
        for (int p = 0; p < NUM_PLANES; p++) begin
            if (pick_q.sel[p]) word = word | ram_rdata[p*DATA_W +: DATA_W];
        end
        rdata = (ack && pick_q.rd && !pick_q.none) ? word : '0;
    end

    // R6: at most one plane supplies read data
    a_r6_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_q.sel));
    // R4: a read with no enabled plane returns zero
    a_r4_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pick_q.none) |-> rdata == '0);
endmodule

// File: rtl/vw_disp_tap.sv
module vw_disp_tap #(
    parameter int NUM_PLANES = 3,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         disp_req,
    input  logic [ADDR_W-1:0]            disp_addr,
    input  logic [$clog2(DATA_W)-1:0]    disp_bit,
    input  logic [NUM_PLANES*DATA_W-1:0] ram_rdata,
    output logic                         disp_valid,
    output logic [NUM_PLANES*DATA_W-1:0] disp_rdata,
    output logic [NUM_PLANES-1:0]        disp_pix
);
    import vw_pkg::*;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int DISP_WORDS = DEPTH - DEPTH / HIDDEN_DIV;
    localparam int BIT_W      = $clog2(DATA_W);

    typedef struct packed {
        logic             valid;
        logic             vis;
        logic [BIT_W-1:0] bsel;
    } tap_t;

    tap_t tap_d, tap_q;

    always_comb begin
        tap_d       = tap_q;
        tap_d.valid = disp_req;
        if (disp_req) begin
            tap_d.vis  = disp_addr < ADDR_W'(DISP_WORDS);
            tap_d.bsel = disp_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tap_d;
    end

    assign disp_valid = tap_q.valid;
    generate
        for (genvar p = 0; p < NUM_PLANES; p++) begin : g_pix
            logic [DATA_W-1:0] w;
            assign w = (tap_q.valid && tap_q.vis) ? ram_rdata[p*DATA_W +: DATA_W] : '0;
            assign disp_rdata[p*DATA_W +: DATA_W] = w;
            assign disp_pix[p] = w[tap_q.bsel];
        end
    endgenerate

    // R9: a fetch is answered on the next cycle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        disp_req |=> disp_valid);
    // R10: hidden area reads back as zero on the display side
    a_r10_hidden_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !tap_q.vis) |-> disp_rdata == '0);
endmodule

// File: rtl/vw_bus_window.sv
module vw_bus_window #(
    parameter int NUM_PLANES = 3,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_req,
    input  logic                                 bus_we,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic [DATA_W-1:0]                    bus_wdata,
    input  logic [DATA_W/8-1:0]                  bus_be,
    output logic                                 bus_ack,
    output logic                                 bus_wait,
    output logic [DATA_W-1:0]                    bus_rdata,
    input  logic                                 reg_we,
    input  logic [$clog2(NUM_PLANES+2)-1:0]      reg_sel,
    input  logic [DATA_W-1:0]                    reg_wdata,
    input  logic                                 xfer_done,
    output logic [NUM_PLANES*DATA_W-1:0]         plane_ctl,
    output logic [NUM_PLANES-1:0]                plane_mref,
    output logic [DATA_W-1:0]                    xfer_x,
    output logic [DATA_W-1:0]                    xfer_y,
    input  logic                                 disp_req,
    input  logic [ADDR_W-1:0]                    disp_addr,
    input  logic [$clog2(DATA_W)-1:0]            disp_bit,
    output logic                                 disp_valid,
    output logic [NUM_PLANES*DATA_W-1:0]         disp_rdata,
    output logic [NUM_PLANES-1:0]                disp_pix
);
    localparam int SEL_W = $clog2(NUM_PLANES + 2);

    typedef struct packed {
        logic ack;
    } port_t;

    port_t port_d, port_q;
    logic                         any_en;
    logic                         bus_go;
    logic [NUM_PLANES-1:0]        ram_en;
    logic [NUM_PLANES-1:0]        ram_we;
    logic [ADDR_W-1:0]            ram_addr;
    logic [NUM_PLANES*DATA_W-1:0] ram_rdata;

    always_comb begin
        any_en     = |plane_mref;
        bus_wait   = bus_req && !port_q.ack && disp_req && any_en;
        bus_go     = bus_req && !port_q.ack && !bus_wait;
        port_d     = port_q;
        port_d.ack = bus_go;
        ram_addr   = disp_req ? disp_addr : bus_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign bus_ack = port_q.ack;

    vw_ctl_regs #(.NUM_PLANES(NUM_PLANES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .xfer_done  (xfer_done),
        .plane_ctl  (plane_ctl),
        .plane_mref (plane_mref),
        .xfer_x     (xfer_x),
        .xfer_y     (xfer_y)
    );

    generate
        for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
            assign ram_en[p] = disp_req || (bus_go && plane_mref[p]);
            assign ram_we[p] = bus_go && bus_we && plane_mref[p];
            vw_plane_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
                .clk   (clk),
                .en    (ram_en[p]),
                .we    (ram_we[p]),
                .be    (bus_be),
                .addr  (ram_addr),
                .wdata (bus_wdata),
                .rdata (ram_rdata[p*DATA_W +: DATA_W])
            );
        end
    endgenerate

    vw_rd_pick #(.NUM_PLANES(NUM_PLANES), .DATA_W(DATA_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (bus_go),
        .is_read   (!bus_we),
        .plane_en  (plane_mref),
        .ram_rdata (ram_rdata),
        .ack       (port_q.ack),
        .rdata     (bus_rdata)
    );

    vw_disp_tap #(.NUM_PLANES(NUM_PLANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_req   (disp_req),
        .disp_addr  (disp_addr),
        .disp_bit   (disp_bit),
        .ram_rdata  (ram_rdata),
        .disp_valid (disp_valid),
        .disp_rdata (disp_rdata),
        .disp_pix   (disp_pix)
    );

    // R11: a stalled access is not acknowledged next cycle
    a_r11_wait_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |=> !bus_ack);
    // R8: acknowledge lasts exactly one cycle
    a_r8_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    // R5: an accepted write reaches every enabled plane
    a_r5_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_go && bus_we) |-> $countones(ram_we) == $countones(plane_mref));
    // R4: no plane enabled means no plane written
    a_r4_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_mref == '0) |-> ram_we == '0);
endmodule

// File: tb/vw_bus_window_tb.sv
module vw_bus_window_tb_top;
    localparam int NP    = 3;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;
    localparam int DISPW = DEPTH - DEPTH / 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 0, bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [1:0]    bus_be = 2'b11;
    logic          bus_ack, bus_wait;
    logic [DW-1:0] bus_rdata;
    logic          reg_we = 0;
    logic [2:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          xfer_done = 1'b1;
    logic [NP*DW-1:0] plane_ctl;
    logic [NP-1:0] plane_mref;
    logic [DW-1:0] xfer_x, xfer_y;
    logic          disp_req = 0;
    logic [AW-1:0] disp_addr = '0;
    logic [3:0]    disp_bit = '0;
    logic          disp_valid;
    logic [NP*DW-1:0] disp_rdata;
    logic [NP-1:0] disp_pix;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vw_bus_window #(.NUM_PLANES(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [DW-1:0] m_mem [NP][DEPTH];
    logic [DW-1:0] m_ctl [NP];
    logic [DW-1:0] m_x, m_y, m_rdata;
    logic [DW-1:0] m_drd [NP];
    logic          m_ack, m_isrd, m_dv;
    logic [3:0]    m_bit;

    function automatic logic [NP-1:0] m_en();
        logic [NP-1:0] e;
        for (int p = 0; p < NP; p++) e[p] = m_ctl[p][5];
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack = 0; m_isrd = 0; m_dv = 0; m_x = 0; m_y = 0; m_rdata = 0; m_bit = 0;
            for (int p = 0; p < NP; p++) begin m_ctl[p] = 0; m_drd[p] = 0; end
        end else begin
            logic [NP-1:0] en;
            logic w, go;
            en = m_en();
            w  = bus_req && !m_ack && disp_req && (en != 0);
            go = bus_req && !m_ack && !w;
            m_dv = disp_req;
            if (disp_req) begin
                m_bit = disp_bit;
                for (int p = 0; p < NP; p++)
                    m_drd[p] = (int'(disp_addr) < DISPW) ? m_mem[p][disp_addr] : '0;
            end
            if (go) begin
                m_isrd = !bus_we;
                if (bus_we) begin
                    for (int p = 0; p < NP; p++) if (en[p]) begin
                        if (bus_be[0]) m_mem[p][bus_addr][7:0]  = bus_wdata[7:0];
                        if (bus_be[1]) m_mem[p][bus_addr][15:8] = bus_wdata[15:8];
                    end
                end else begin
                    m_rdata = '0;
                    for (int p = NP - 1; p >= 0; p--) if (en[p]) m_rdata = m_mem[p][bus_addr];
                end
            end
            m_ack = go;
            if (reg_we) begin
                if (reg_sel < 3 && xfer_done) m_ctl[reg_sel] = reg_wdata;
                else if (reg_sel == 3) m_x = reg_wdata;
                else if (reg_sel == 4) m_y = reg_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8 bus_ack", bus_ack, m_ack);
            chk("R11 bus_wait", bus_wait, bus_req && !m_ack && disp_req && (m_en() != 0));
            if (m_ack && m_isrd) chk("R6/R4 bus_rdata", bus_rdata, m_rdata);
            chk("R9 disp_valid", disp_valid, m_dv);
            if (m_dv) for (int p = 0; p < NP; p++) begin
                chk("R9/R10 disp_rdata", disp_rdata[p*DW +: DW], m_drd[p]);
                chk("R9 disp_pix", disp_pix[p], m_drd[p][m_bit]);
            end
            for (int p = 0; p < NP; p++) chk("R12 plane_ctl", plane_ctl[p*DW +: DW], m_ctl[p]);
            chk("R3 plane_mref", plane_mref, m_en());
            chk("R12 xfer_x", xfer_x, m_x);
            chk("R12 xfer_y", xfer_y, m_y);
        end
    end

    task automatic bus_rw(input logic we, input int a, input logic [DW-1:0] d,
                          input logic [1:0] be, output logic [DW-1:0] rd);
        bus_req = 1; bus_we = we; bus_addr = AW'(a); bus_wdata = d; bus_be = be;
        do begin @(posedge clk); #1; end while (!bus_ack);
        rd = bus_rdata;
        bus_req = 0;
    endtask

    task automatic ctl_wr(input int sel, input logic [DW-1:0] d);
        reg_we = 1; reg_sel = 3'(sel); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic disp_fetch(input int a, input int b);
        disp_req = 1; disp_addr = AW'(a); disp_bit = 4'(b);
        @(posedge clk); #1;
        disp_req = 0;
    endtask

    task automatic set_en(input logic [2:0] e);
        for (int p = 0; p < NP; p++) ctl_wr(p, e[p] ? 16'h0020 : 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 ack", bus_ack, 0); chk("R1 wait", bus_wait, 0);
        chk("R1 disp_valid", disp_valid, 0); chk("R1 ctl", plane_ctl, 0);
        chk("R1 x", xfer_x, 0); chk("R1 y", xfer_y, 0);
        // initialise every plane
        set_en(3'b111);
        for (int a = 0; a < DEPTH; a++) begin
            bus_rw(1, a, 16'h0000, 2'b11, rd);
            for (int p = 0; p < NP; p++) m_mem[p][a] = 16'h0000;
        end
        // R3 / R2: one plane at a time, same address
        set_en(3'b001); bus_rw(1, 5, 16'h1111, 2'b11, rd);
        set_en(3'b010); bus_rw(1, 5, 16'h2222, 2'b11, rd);
        set_en(3'b000); ctl_wr(2, 16'hFFFF); bus_rw(1, 5, 16'h3333, 2'b11, rd);
        ctl_wr(2, 16'hFFDF);
        chk("R3 other bits no enable", plane_mref, 3'b000);
        bus_rw(1, 5, 16'h4444, 2'b11, rd);
        // R4: nothing enabled
        bus_rw(1, 6, 16'hDEAD, 2'b11, rd);
        bus_rw(0, 5, 16'h0, 2'b11, rd);
        chk("R4 read none zero", rd, 16'h0000);
        disp_fetch(5, 0);
        chk("R2 plane0", disp_rdata[15:0], 16'h1111);
        chk("R2 plane1", disp_rdata[31:16], 16'h2222);
        chk("R3 plane2", disp_rdata[47:32], 16'h3333);
        // R5 broadcast
        set_en(3'b111);
        bus_rw(1, 7, 16'hA5C3, 2'b11, rd);
        disp_fetch(7, 0);
        chk("R5 broadcast", disp_rdata, {3{16'hA5C3}});
        disp_fetch(6, 0);
        chk("R4 write dropped", disp_rdata, 48'h0);
        // R6 priority
        bus_rw(0, 5, 0, 2'b11, rd); chk("R6 plane0 first", rd, 16'h1111);
        set_en(3'b110); bus_rw(0, 5, 0, 2'b11, rd); chk("R6 plane1 next", rd, 16'h2222);
        set_en(3'b100); bus_rw(0, 5, 0, 2'b11, rd); chk("R6 plane2 last", rd, 16'h3333);
        // R7 byte strobes
        set_en(3'b111);
        bus_rw(1, 7, 16'h0000, 2'b01, rd);
        bus_rw(0, 7, 0, 2'b11, rd); chk("R7 low lane", rd, 16'hA500);
        bus_rw(1, 7, 16'h7788, 2'b10, rd);
        bus_rw(1, 7, 16'hFFFF, 2'b00, rd);
        bus_rw(0, 7, 0, 2'b11, rd); chk("R7 high lane", rd, 16'h7700);
        // R9 pixel order
        bus_rw(1, 0, 16'h0001, 2'b11, rd);
        bus_rw(1, 1, 16'h8000, 2'b11, rd);
        disp_fetch(0, 0); chk("R9 top-left pixel", disp_pix, 3'b111);
        disp_fetch(0, 1); chk("R9 pixel 1", disp_pix, 3'b000);
        disp_fetch(1, 15); chk("R9 pixel 31", disp_pix, 3'b111);
        // R10 hidden area, R2 still reachable from the bus
        bus_rw(1, 1000, 16'hFFFF, 2'b11, rd);
        disp_fetch(1000, 0); chk("R10 hidden zero", disp_rdata, 48'h0);
        bus_rw(0, 1000, 0, 2'b11, rd); chk("R2 hidden by bus", rd, 16'hFFFF);
        disp_fetch(DISPW - 1, 0); chk("R10 last visible", disp_rdata, 48'h0);
        // R11 collision
        bus_req = 1; bus_we = 0; bus_addr = 7; disp_req = 1; disp_addr = 5;
        #1 chk("R11 wait raised", bus_wait, 1);
        @(posedge clk); #1;
        disp_req = 0;
        chk("R11 no ack while stalled", bus_ack, 0);
        @(posedge clk); #1;
        chk("R8 ack after stall", bus_ack, 1);
        chk("R8 rdata after stall", bus_rdata, 16'h7700);
        bus_req = 0;
        // R12 busy lock
        xfer_done = 0;
        ctl_wr(0, 16'h0000);
        chk("R12 ctl ignored busy", plane_ctl[15:0], 16'h0020);
        ctl_wr(3, 16'h0123); chk("R12 x busy", xfer_x, 16'h0123);
        ctl_wr(4, 16'h0456); chk("R12 y busy", xfer_y, 16'h0456);
        xfer_done = 1;
        ctl_wr(0, 16'h0000);
        chk("R12 ctl accepted idle", plane_ctl[15:0], 16'h0000);
        // random traffic checked by the model
        for (int i = 0; i < 3000; i++) begin
            bus_req   = $urandom_range(0, 1);
            bus_we    = $urandom_range(0, 1);
            bus_addr  = AW'($urandom_range(0, 15));
            bus_wdata = DW'($urandom);
            bus_be    = 2'($urandom);
            disp_req  = ($urandom_range(0, 3) == 0);
            disp_addr = AW'($urandom_range(0, 15));
            disp_bit  = 4'($urandom);
            reg_we    = ($urandom_range(0, 7) == 0);
            reg_sel   = 3'($urandom_range(0, 5));
            reg_wdata = DW'($urandom);
            xfer_done = ($urandom_range(0, 3) != 0);
            @(posedge clk); #1;
        end
        bus_req = 0; disp_req = 0; reg_we = 0;
        repeat (3) @(posedge clk);
        #1;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule